// File: doc/BRIEF.md
# Vector Rename Table with Zero Flags

This block keeps the speculative mapping from a small set of wide architectural vector registers to a shared pool of physical half-register entries. Each register is 256 bits wide and has two 128-bit halves. Each half has its own physical entry and its own zero flag. A write to a half takes a fresh entry from the pool. An instruction that zeroes one half, or that clears the upper half of every register at once, only raises the flags. It does not allocate an entry and writes nothing into the data array.

Entries that a rename displaces are not returned to the pool at once. Each renamed instruction leaves a record in an in-order retirement queue, and the displaced entries return to the pool only when that record retires. A branch takes one of four checkpoint slots, named by a 2-bit branch ID. Each slot holds the whole mapping and both flag vectors. A mispredict reloads that state and discards every younger record without freeing anything the record held. The block then returns to the pool only the entries allocated after the branch. This means a rolled-back mapping, including one undone after an upper-zeroing step, always names an entry that nobody has reused. The pool is shared by two hardware threads, so this rule keeps one thread from reading the other thread's stale data.

A single read port turns an architectural half into either a data-array read or a constant zero.

Top module: `vrt_rename_top`

## Requirements
- R1: After reset every half of every register is flagged zero, all 12 physical entries are free, the retirement queue is empty and no checkpoint is held.
- R2: An accepted write (op_kind 0, op_half 0 = lower, 1 = upper) raises alloc_valid in the same cycle and allocates the lowest-numbered free entry. From the next cycle that half maps to the new entry with its zero flag clear.
- R3: An accepted zero-one-half operation (op_kind 1) allocates no entry and sets only that half's flag. A read of a flagged half returns all zeros with rf_ren low.
- R4: An accepted upper-zeroing operation (op_kind 2) sets the upper flag of every register and leaves every lower half unchanged.
- R5: A read of an unflagged half drives rf_ren high and rf_raddr with its mapped entry, and passes rf_rdata to rd_data.
- R6: An entry displaced by a write or a zeroing becomes free only in the cycle after the record of that instruction retires. Records retire in program order.
- R7: op_ready is low when the retirement queue holds 16 records, when a write finds no free entry, or when a branch (op_kind 3) names a busy checkpoint ID.
- R8: A mispredict on a held checkpoint restores every mapping and both flag vectors to their values just before that branch. It frees the entries allocated after the branch, discards younger records without freeing their entries, and drops younger checkpoints.
- R9: A correct resolution releases the checkpoint. A branch record at the head of the queue cannot retire (ret_ready low) while its checkpoint is held.
- R10: No physical entry is ever free and, at the same time, named by an unflagged mapping.
- R11: In a cycle with an accepted mispredict, op_ready is low and the operation presented has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Rename operation present |
| op_kind | input | 2 | 0 write, 1 zero one half, 2 zero all upper halves, 3 branch |
| op_areg | input | 2 | Architectural register |
| op_half | input | 1 | 0 lower, 1 upper |
| op_br_id | input | 2 | Checkpoint ID for a branch |
| op_ready | output | 1 | Operation accepted this cycle when valid |
| alloc_valid | output | 1 | A physical entry is allocated |
| alloc_preg | output | 4 | Allocated entry number |
| br_res_valid | input | 1 | Branch resolution present |
| br_res_id | input | 2 | Checkpoint ID being resolved |
| br_res_mispredict | input | 1 | 1 restore, 0 release |
| ret_valid | input | 1 | Retire the oldest record |
| ret_ready | output | 1 | Oldest record may retire |
| rd_areg | input | 2 | Read port register |
| rd_half | input | 1 | Read port half |
| rf_ren | output | 1 | Data array read enable |
| rf_raddr | output | 4 | Data array read entry |
| rf_rdata | input | 128 | Data array read data |
| rd_data | output | 128 | Operand value |

## Verification
A corrupted mapping shows on the read port in the next cycle as a wrong rf_raddr or a wrong rf_ren. A lost or doubled free entry shows as a wrong alloc_preg at the next write. Many such faults stay hidden until after a mispredict or a retirement, so the bench keeps its own model of the mappings, records and checkpoints. It compares every output on every cycle, including through long random mixes of branches, restores and retirements, and so catches a fault on the first cycle it reaches a port.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
    localparam int NAREG    = 4;
    localparam int AW       = $clog2(NAREG);
    localparam int NPREG    = 12;
    localparam int PW       = $clog2(NPREG);
    localparam int NCKPT    = 4;
    localparam int CW       = $clog2(NCKPT);
    localparam int RQ_DEPTH = 16;
    localparam int RQW      = $clog2(RQ_DEPTH);
    localparam int HALF_W   = 128;

    typedef enum logic [1:0] {
        OP_WRITE      = 2'd0,
        OP_ZERO       = 2'd1,
        OP_ZERO_UPPER = 2'd2,
        OP_BRANCH     = 2'd3
    } op_kind_e;

    typedef logic [NPREG-1:0] pmask_t;
    typedef logic [PW-1:0]    preg_t;

    typedef struct packed {
        logic [NAREG-1:0][PW-1:0] map_lo;
        logic [NAREG-1:0][PW-1:0] map_hi;
        logic [NAREG-1:0]         zf_lo;
        logic [NAREG-1:0]         zf_hi;
        logic [RQW:0]             rq_tail;
    } snap_t;

    typedef struct packed {
        pmask_t          rel;
        logic            is_br;
        logic [CW-1:0]   bid;
    } rq_rec_t;

    function automatic pmask_t onehot(preg_t idx);
        pmask_t r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

    function automatic preg_t lowest_set(pmask_t m);
        preg_t r;
        r = '0;
        for (int i = NPREG - 1; i >= 0; i--) begin
            if (m[i]) r = PW'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/vrt_free_pool.sv
module vrt_free_pool
    import vrt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take_en,
    input  preg_t  take_idx,
    input  pmask_t rel_mask,
    output pmask_t free_mask,
    output logic   any_free,
    output preg_t  low_idx
);
    pmask_t take_mask;

    assign take_mask = take_en ? onehot(take_idx) : '0;
    assign any_free  = |free_mask;
    assign low_idx   = lowest_set(free_mask);

    always_ff @(posedge clk) begin
        if (rst) free_mask <= '1;
        else     free_mask <= (free_mask & ~take_mask) | rel_mask;
    end
endmodule

// File: rtl/vrt_retire_q.sv
module vrt_retire_q
    import vrt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         push_en,
    input  rq_rec_t      push_rec,
    input  logic         pop_en,
    input  logic         restore_en,
    input  logic [RQW:0] restore_tail,
    output logic [RQW:0] tail_ptr,
    output rq_rec_t      head_rec,
    output logic         full,
    output logic         empty
);
    rq_rec_t      slots [RQ_DEPTH];
    logic [RQW:0] head;
    logic [RQW:0] used;

    assign used     = tail_ptr - head;
    assign full     = (used == (RQW+1)'(RQ_DEPTH));
    assign empty    = (used == '0);
    assign head_rec = slots[head[RQW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            head     <= '0;
            tail_ptr <= '0;
        end else begin
            if (pop_en) head <= head + 1'b1;
            if (restore_en)   tail_ptr <= restore_tail;
            else if (push_en) tail_ptr <= tail_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en && !restore_en) slots[tail_ptr[RQW-1:0]] <= push_rec;
    end
endmodule

// File: rtl/vrt_ckpt_store.sv
module vrt_ckpt_store
    import vrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             save_en,
    input  logic [CW-1:0]    save_id,
    input  snap_t            save_snap,
    input  logic             mark_en,
    input  pmask_t           mark_mask,
    input  logic             drop_en,
    input  logic             rel_en,
    input  logic [CW-1:0]    sel_id,
    output logic [NCKPT-1:0] valid_o,
    output snap_t            sel_snap,
    output pmask_t           sel_alloc
);
    snap_t            snaps  [NCKPT];
    pmask_t           allocs [NCKPT];
    logic [NCKPT-1:0] yrows  [NCKPT];

    assign sel_snap  = snaps[sel_id];
    assign sel_alloc = allocs[sel_id];

    for (genvar i = 0; i < NCKPT; i++) begin : g_slot
        logic             vld;
        snap_t            snp;
        pmask_t           alm;
        logic [NCKPT-1:0] yrow;
        logic             kill;

        assign kill       = drop_en && ((sel_id == CW'(i)) || yrows[sel_id][i]);
        assign valid_o[i] = vld;
        assign snaps[i]   = snp;
        assign allocs[i]  = alm;
        assign yrows[i]   = yrow;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld  <= 1'b0;
                snp  <= '0;
                alm  <= '0;
                yrow <= '0;
            end else if (kill || (rel_en && sel_id == CW'(i))) begin
                vld <= 1'b0;
            end else if (save_en && save_id == CW'(i)) begin
                vld  <= 1'b1;
                snp  <= save_snap;
                alm  <= '0;
                yrow <= '0;
            end else if (vld) begin
                if (mark_en) alm <= alm | mark_mask;
                if (save_en) yrow[save_id] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vrt_rename_top.sv
module vrt_rename_top
    import vrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [AW-1:0]     op_areg,
    input  logic              op_half,
    input  logic [CW-1:0]     op_br_id,
    output logic              op_ready,
    output logic              alloc_valid,
    output logic [PW-1:0]     alloc_preg,
    input  logic              br_res_valid,
    input  logic [CW-1:0]     br_res_id,
    input  logic              br_res_mispredict,
    input  logic              ret_valid,
    output logic              ret_ready,
    input  logic [AW-1:0]     rd_areg,
    input  logic              rd_half,
    output logic              rf_ren,
    output logic [PW-1:0]     rf_raddr,
    input  logic [HALF_W-1:0] rf_rdata,
    output logic [HALF_W-1:0] rd_data
);
    op_kind_e                 kind;
    logic [NAREG-1:0][PW-1:0] map_lo, map_hi;
    logic [NAREG-1:0]         zf_lo, zf_hi;

    pmask_t           free_mask;
    logic             any_free;
    preg_t            low_idx;
    logic [RQW:0]     tail_ptr;
    rq_rec_t          head_rec, push_rec;
    logic             rq_full, rq_empty;
    logic [NCKPT-1:0] ck_valid;
    snap_t            cur_snap, sel_snap;
    pmask_t           sel_alloc;

    logic   restore_fire, resolve_ok, op_fire, ret_fire;
    logic   old_zf, rd_zf;
    preg_t  old_map;
    pmask_t pool_rel;

    assign kind = op_kind_e'(op_kind);

    assign restore_fire = br_res_valid &&  br_res_mispredict && ck_valid[br_res_id];
    assign resolve_ok   = br_res_valid && !br_res_mispredict && ck_valid[br_res_id];

    assign op_ready = !restore_fire && !rq_full
                    && ((kind != OP_WRITE)  || any_free)
                    && ((kind != OP_BRANCH) || !ck_valid[op_br_id]);
    assign op_fire     = op_valid && op_ready;
    assign alloc_valid = op_fire && (kind == OP_WRITE);
    assign alloc_preg  = low_idx;

    assign ret_ready = !rq_empty && !(head_rec.is_br && ck_valid[head_rec.bid]);
    assign ret_fire  = ret_valid && ret_ready;
    assign pool_rel  = (ret_fire ? head_rec.rel : '0) | (restore_fire ? sel_alloc : '0);

    assign old_zf  = op_half ? zf_hi[op_areg]  : zf_lo[op_areg];
    assign old_map = op_half ? map_hi[op_areg] : map_lo[op_areg];

    // Record of what this operation displaces, freed only at its retirement.
    always_comb begin
        push_rec = '0;
        unique case (kind)
            OP_WRITE, OP_ZERO: begin
                if (!old_zf) push_rec.rel = onehot(old_map);
            end
            OP_ZERO_UPPER: begin
                for (int r = 0; r < NAREG; r++) begin
                    if (!zf_hi[r]) push_rec.rel = push_rec.rel | onehot(map_hi[r]);
                end
            end
            OP_BRANCH: begin
                push_rec.is_br = 1'b1;
                push_rec.bid   = op_br_id;
            end
            default: ;
        endcase
    end

    always_comb begin
        cur_snap         = '0;
        cur_snap.map_lo  = map_lo;
        cur_snap.map_hi  = map_hi;
        cur_snap.zf_lo   = zf_lo;
        cur_snap.zf_hi   = zf_hi;
        cur_snap.rq_tail = tail_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_lo <= '0;
            map_hi <= '0;
            zf_lo  <= '1;
            zf_hi  <= '1;
        end else if (restore_fire) begin
            map_lo <= sel_snap.map_lo;
            map_hi <= sel_snap.map_hi;
            zf_lo  <= sel_snap.zf_lo;
            zf_hi  <= sel_snap.zf_hi;
        end else if (op_fire) begin
            unique case (kind)
                OP_WRITE: begin
                    if (op_half) begin
                        map_hi[op_areg] <= low_idx;
                        zf_hi[op_areg]  <= 1'b0;
                    end else begin
                        map_lo[op_areg] <= low_idx;
                        zf_lo[op_areg]  <= 1'b0;
                    end
                end
                OP_ZERO: begin
                    if (op_half) zf_hi[op_areg] <= 1'b1;
                    else         zf_lo[op_areg] <= 1'b1;
                end
                OP_ZERO_UPPER: zf_hi <= '1;
                default: ;
            endcase
        end
    end

    assign rd_zf    = rd_half ? zf_hi[rd_areg]  : zf_lo[rd_areg];
    assign rf_raddr = rd_half ? map_hi[rd_areg] : map_lo[rd_areg];
    assign rf_ren   = !rd_zf;
    assign rd_data  = rd_zf ? '0 : rf_rdata;

    vrt_free_pool u_pool (
        .clk       (clk),
        .rst       (rst),
        .take_en   (alloc_valid),
        .take_idx  (low_idx),
        .rel_mask  (pool_rel),
        .free_mask (free_mask),
        .any_free  (any_free),
        .low_idx   (low_idx)
    );

    vrt_retire_q u_rq (
        .clk          (clk),
        .rst          (rst),
        .push_en      (op_fire),
        .push_rec     (push_rec),
        .pop_en       (ret_fire),
        .restore_en   (restore_fire),
        .restore_tail (sel_snap.rq_tail),
        .tail_ptr     (tail_ptr),
        .head_rec     (head_rec),
        .full         (rq_full),
        .empty        (rq_empty)
    );

    vrt_ckpt_store u_ckpt (
        .clk       (clk),
        .rst       (rst),
        .save_en   (op_fire && kind == OP_BRANCH),
        .save_id   (op_br_id),
        .save_snap (cur_snap),
        .mark_en   (alloc_valid),
        .mark_mask (onehot(low_idx)),
        .drop_en   (restore_fire),
        .rel_en    (resolve_ok),
        .sel_id    (br_res_id),
        .valid_o   (ck_valid),
        .sel_snap  (sel_snap),
        .sel_alloc (sel_alloc)
    );
endmodule

// File: rtl/vrt_rename_chk.sv
module vrt_rename_chk
    import vrt_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     op_valid,
    input logic [1:0]               op_kind,
    input logic                     op_ready,
    input logic                     alloc_valid,
    input logic [PW-1:0]            alloc_preg,
    input logic                     restore_fire,
    input pmask_t                   free_mask,
    input logic [NAREG-1:0][PW-1:0] map_lo,
    input logic [NAREG-1:0][PW-1:0] map_hi,
    input logic [NAREG-1:0]         zf_lo,
    input logic [NAREG-1:0]         zf_hi
);
    pmask_t live_mask;

    always_comb begin
        live_mask = '0;
        for (int r = 0; r < NAREG; r++) begin
            if (!zf_lo[r]) live_mask = live_mask | onehot(map_lo[r]);
            if (!zf_hi[r]) live_mask = live_mask | onehot(map_hi[r]);
        end
    end

    assert_no_shared_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (free_mask & live_mask) == '0);

    assert_zero_no_alloc_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_kind != 2'd0) |-> !alloc_valid);

    assert_alloc_from_free_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> free_mask[alloc_preg]);

    assert_alloc_taken_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> !free_mask[$past(alloc_preg)]);

    assert_empty_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd0 && free_mask == '0) |-> !op_ready);

    assert_upper_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_kind == 2'd2) |=> (&zf_hi));

    assert_restore_blocks_op_R11: assert property (@(posedge clk) disable iff (rst)
        restore_fire |-> !op_ready);
endmodule

bind vrt_rename_top vrt_rename_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .op_ready     (op_ready),
    .alloc_valid  (alloc_valid),
    .alloc_preg   (alloc_preg),
    .restore_fire (restore_fire),
    .free_mask    (free_mask),
    .map_lo       (map_lo),
    .map_hi       (map_hi),
    .zf_lo        (zf_lo),
    .zf_hi        (zf_hi)
);

// File: tb/vrt_rename_top_tb_top.sv
module vrt_rename_top_tb_top;
    localparam int CLK_P = 10;
    localparam int NA = 4;
    localparam int NP = 12;
    localparam int NC = 4;
    localparam int RQD = 16;

    logic clk = 1'b0;
    logic rst;
    logic op_valid, op_half, op_ready, alloc_valid;
    logic [1:0] op_kind, op_areg, op_br_id;
    logic [3:0] alloc_preg, rf_raddr;
    logic br_res_valid, br_res_mispredict, ret_valid, ret_ready;
    logic [1:0] br_res_id, rd_areg;
    logic rd_half, rf_ren;
    logic [127:0] rf_rdata, rd_data;

    always #(CLK_P/2) clk = ~clk;

    vrt_rename_top dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_areg(op_areg), .op_half(op_half), .op_br_id(op_br_id),
        .op_ready(op_ready), .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
        .br_res_valid(br_res_valid), .br_res_id(br_res_id),
        .br_res_mispredict(br_res_mispredict), .ret_valid(ret_valid),
        .ret_ready(ret_ready), .rd_areg(rd_areg), .rd_half(rd_half),
        .rf_ren(rf_ren), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rd_data(rd_data)
    );

    // Behavioural reference model
    typedef struct {
        int          seq;
        bit [NP-1:0] rel;
        int          alloc;
        bit          is_br;
        int          bid;
    } rec_t;

    int   m_lo [NA], m_hi [NA];
    bit   z_lo [NA], z_hi [NA];
    bit   fr   [NP];
    rec_t q[$];
    bit   cv [NC];
    int   cseq [NC];
    int   s_lo [NC][NA], s_hi [NC][NA];
    bit   sz_lo [NC][NA], sz_hi [NC][NA];
    int   seq_ctr;

    int    errors = 0;
    int    checks = 0;
    int    stall_seen = 0;
    int    restore_seen = 0;
    string phase = "R1";

    task automatic check(bit ok, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < NA; r++) begin
            m_lo[r] = 0; m_hi[r] = 0; z_lo[r] = 1; z_hi[r] = 1;
        end
        for (int i = 0; i < NP; i++) fr[i] = 1;
        for (int c = 0; c < NC; c++) cv[c] = 0;
        q.delete();
        seq_ctr = 0;
    endtask

    task automatic idle();
        op_valid = 0; op_kind = 0; op_areg = 0; op_half = 0; op_br_id = 0;
        br_res_valid = 0; br_res_id = 0; br_res_mispredict = 0; ret_valid = 0;
    endtask

    task automatic tick();
        bit restore, resolve, fire, rfire, e_ready, e_rr, e_alloc, rz;
        int nf, low, rmap, k, a, bseq;
        logic [127:0] e_data;
        rec_t nr;
        rf_rdata = {$urandom, $urandom, $urandom, $urandom};
        #1;
        k = int'(op_kind);
        a = int'(op_areg);
        restore = br_res_valid &&  br_res_mispredict && cv[br_res_id];
        resolve = br_res_valid && !br_res_mispredict && cv[br_res_id];
        nf = 0; low = -1;
        for (int i = 0; i < NP; i++) if (fr[i]) begin nf++; if (low < 0) low = i; end
        e_ready = !restore && q.size() < RQD && (k != 0 || nf > 0) && (k != 3 || !cv[op_br_id]);
        fire    = op_valid && e_ready;
        e_alloc = fire && k == 0;
        e_rr    = q.size() > 0 && !(q[0].is_br && cv[q[0].bid]);
        rfire   = ret_valid && e_rr;
        if (op_valid && k == 0 && !e_ready && !restore) stall_seen++;
        if (restore) restore_seen++;

        check(op_ready == e_ready, "R7 op_ready", op_ready, e_ready);
        check(alloc_valid == e_alloc, "R2 alloc_valid", alloc_valid, e_alloc);
        if (e_alloc) begin
            check(alloc_preg == low[3:0], "R2 alloc_preg lowest free", alloc_preg, low);
            for (int r = 0; r < NA; r++) begin
                check(!((!z_lo[r] && m_lo[r] == int'(alloc_preg)) ||
                        (!z_hi[r] && m_hi[r] == int'(alloc_preg))),
                      "R10 allocated entry is live", alloc_preg, r);
            end
        end
        check(ret_ready == e_rr, "R9 ret_ready", ret_ready, e_rr);
        rz   = rd_half ? z_hi[rd_areg] : z_lo[rd_areg];
        rmap = rd_half ? m_hi[rd_areg] : m_lo[rd_areg];
        e_data = rz ? '0 : rf_rdata;
        check(rf_ren == !rz, "R3/R5 rf_ren", rf_ren, !rz);
        if (!rz) check(rf_raddr == rmap[3:0], "R5 rf_raddr", rf_raddr, rmap);
        check(rd_data == e_data, "R3/R5 rd_data", rd_data, e_data);

        // Advance the model by one clock
        if (rfire) begin
            for (int i = 0; i < NP; i++) if (q[0].rel[i]) fr[i] = 1;
            void'(q.pop_front());
        end
        if (restore) begin
            bseq = cseq[br_res_id];
            for (int j = q.size() - 1; j >= 0; j--) begin
                if (q[j].seq > bseq) begin
                    if (q[j].alloc >= 0) fr[q[j].alloc] = 1;
                    q.delete(j);
                end
            end
            for (int r = 0; r < NA; r++) begin
                m_lo[r] = s_lo[br_res_id][r]; m_hi[r] = s_hi[br_res_id][r];
                z_lo[r] = sz_lo[br_res_id][r]; z_hi[r] = sz_hi[br_res_id][r];
            end
            for (int c = 0; c < NC; c++) if (cv[c] && cseq[c] >= bseq) cv[c] = 0;
        end else if (resolve) begin
            cv[br_res_id] = 0;
        end
        if (fire) begin
            nr.seq = seq_ctr; nr.rel = '0; nr.alloc = -1; nr.is_br = 0; nr.bid = 0;
            seq_ctr++;
            if (k == 0 || k == 1) begin
                if (op_half) begin
                    if (!z_hi[a]) nr.rel[m_hi[a]] = 1;
                end else begin
                    if (!z_lo[a]) nr.rel[m_lo[a]] = 1;
                end
            end
            case (k)
                0: begin
                    nr.alloc = low; fr[low] = 0;
                    if (op_half) begin m_hi[a] = low; z_hi[a] = 0; end
                    else         begin m_lo[a] = low; z_lo[a] = 0; end
                end
                1: if (op_half) z_hi[a] = 1; else z_lo[a] = 1;
                2: for (int r = 0; r < NA; r++) begin
                    if (!z_hi[r]) nr.rel[m_hi[r]] = 1;
                    z_hi[r] = 1;
                end
                default: begin
                    nr.is_br = 1; nr.bid = int'(op_br_id);
                    cv[op_br_id] = 1; cseq[op_br_id] = nr.seq;
                    for (int r = 0; r < NA; r++) begin
                        s_lo[op_br_id][r] = m_lo[r]; s_hi[op_br_id][r] = m_hi[r];
                        sz_lo[op_br_id][r] = z_lo[r]; sz_hi[op_br_id][r] = z_hi[r];
                    end
                end
            endcase
            q.push_back(nr);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_op(int k, int a, int h, int b);
        idle();
        op_valid = 1; op_kind = k[1:0]; op_areg = a[1:0]; op_half = h[0]; op_br_id = b[1:0];
        tick();
        idle();
    endtask

    task automatic read_all();
        idle();
        for (int r = 0; r < NA; r++) begin
            for (int h = 0; h < 2; h++) begin
                rd_areg = r[1:0]; rd_half = h[0];
                tick();
            end
        end
    endtask

    task automatic retire(int n);
        idle();
        ret_valid = 1;
        for (int i = 0; i < n; i++) tick();
        idle();
    endtask

    task automatic resolve(int id, int mp, int k, int a, int h);
        idle();
        br_res_valid = 1; br_res_id = id[1:0]; br_res_mispredict = mp[0];
        op_valid = (k >= 0); op_kind = (k < 0) ? 2'd0 : k[1:0];
        op_areg = a[1:0]; op_half = h[0];
        tick();
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        rd_areg = 0; rd_half = 0; rf_rdata = '0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        phase = "R1";
        read_all();

        phase = "R2";
        for (int r = 0; r < NA; r++) do_op(0, r, 0, 0);
        for (int r = 0; r < NA; r++) do_op(0, r, 1, 0);
        phase = "R5";
        read_all();

        phase = "R3";
        do_op(1, 1, 0, 0);
        do_op(1, 2, 1, 0);
        read_all();

        phase = "R4";
        do_op(2, 0, 0, 0);
        read_all();

        phase = "R6";
        do_op(0, 3, 0, 0);
        retire(11);
        do_op(0, 0, 0, 0);
        do_op(0, 0, 1, 0);
        retire(2);
        do_op(0, 1, 1, 0);

        phase = "R7";
        stall_seen = 0;
        for (int i = 0; i < 10; i++) do_op(0, i % NA, i % 2, 0);
        check(stall_seen > 0, "R7 write stalled on empty pool", stall_seen, 1);
        retire(RQD + 2);
        for (int i = 0; i < RQD + 2; i++) do_op(1, 0, 0, 0);
        retire(RQD + 2);
        do_op(3, 0, 0, 2);
        do_op(3, 0, 0, 2);
        resolve(2, 0, -1, 0, 0);
        retire(2);

        phase = "R8";
        restore_seen = 0;
        do_op(0, 0, 1, 0);
        do_op(3, 0, 0, 0);
        do_op(2, 0, 0, 0);
        do_op(0, 2, 0, 0);
        do_op(3, 0, 0, 1);
        do_op(0, 1, 1, 0);
        read_all();
        phase = "R9";
        retire(3);
        phase = "R11";
        resolve(0, 1, 0, 3, 1);
        check(restore_seen == 1, "R8 restore accepted", restore_seen, 1);
        phase = "R8";
        read_all();
        do_op(0, 3, 0, 0);
        do_op(0, 3, 1, 0);
        phase = "R9";
        do_op(3, 0, 0, 1);
        retire(2);
        resolve(1, 0, -1, 0, 0);
        retire(4);

        phase = "R10";
        for (int i = 0; i < 3000; i++) begin
            idle();
            op_valid = ($urandom % 3) != 0;
            op_kind  = 2'($urandom % 4);
            op_areg  = 2'($urandom % 4);
            op_half  = 1'($urandom % 2);
            op_br_id = 2'($urandom % 4);
            ret_valid = ($urandom % 3) == 0;
            br_res_valid = ($urandom % 5) == 0;
            br_res_id = 2'($urandom % 4);
            br_res_mispredict = 1'($urandom % 2);
            rd_areg = 2'($urandom % 4);
            rd_half = 1'($urandom % 2);
            tick();
        end
        idle();
        for (int c = 0; c < NC; c++) resolve(c, 0, -1, 0, 0);
        retire(RQD + 1);
        read_all();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule